// File: doc/BRIEF.md
# Reloadable Programmable Clock Divider

This block derives a slower clock from its parent clock by an integer ratio that software programs through two 32-bit registers. The divide value is first written into a staging field. It does not reach the running divider until software completes a two-step handshake. The first step marks the clock as wanting a reload. The second step fires a reload trigger. The new value is then taken at the next output period boundary, so the output never shows a shortened or stretched pulse.

The control word keeps every bit that software writes, so read-modify-write sequences leave unrelated bits intact. Software can poll a busy flag in that word to learn when a requested ratio has become active, instead of waiting a fixed delay. A separate enable bit gates the output. The enable bit is also sampled only at a period boundary, so turning the clock on or off never cuts a pulse short.

The register interface is a plain single-cycle write strobe with a word select, and reads are combinational. The parent clock is the block clock `clk`. For ratio N the output period is N parent cycles. The high phase lasts floor(N/2) parent cycles.

Top module: `reload_clk_divider`

## Requirements
- R1: After a synchronous active-low reset, `clk_out` is 0, the active ratio is 8, the control word reads 0x0000_0000 and the ratio word reads 0x0000_0800.
- R2: With the clock enabled and an active ratio N of 2 or more, `clk_out` repeats with a period of N parent cycles and is high for floor(N/2) of them. A rising edge starts every period.
- R3: Writing the 6-bit ratio field (ratio word bits 13:8) only stages a value. The output period does not change until a reload is performed.
- R4: A control write (word select 0) with both the reload trigger (bit 8) and the reload-force flag (bit 1) set schedules the staged ratio. The new ratio is first used for the period that starts at the next output rising edge, after the current period has completed.
- R5: A control write with the reload trigger set but the reload-force flag clear schedules nothing. Busy stays 0 and the output period is unchanged.
- R6: Control bit 31 reads 1 from the cycle after an accepted reload trigger until the cycle in which the new ratio becomes active, and reads 0 otherwise. Writes to bit 31 are ignored.
- R7: Every other control bit and every ratio-word bit reads back exactly as last written.
- R8: The enable bit is control bit 1+EN_OFFSET (bit 25 by default). While it is clear, `clk_out` stays 0. Changes to it take effect only at a period boundary.
- R9: Staged ratio values 0 and 1 are applied as ratio 2, which gives a period of 2 and a high phase of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 1 | Word select: 0 control, 1 ratio |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word (combinational) |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
The divider is tried with the supported ratios 4, 5, 6 and 8, which separate even from odd high-phase handling. It is also tried with the degenerate values 0 and 1, which show whether the floor of 2 is applied, and with seeded random ratios up to 63, which exercise the counter width and the wrap point. The handshake is checked with reload-force clear, which must not schedule anything, and with a staging write without a trigger. Polling busy right after the trigger shows that the flag rises at once and clears only when the period and high time change. Disabled intervals show that the gate holds the output low.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and helpers for the reloadable clock divider.
// Assumes a single 32-bit register width and one divided clock per instance.
package clkdiv_pkg;
    localparam int CD_DATA_W      = 32;
    localparam int CD_RATIO_W     = 6;
    localparam int CD_RATIO_LSB   = 8;
    localparam int CD_FORCE_BIT   = 1;
    localparam int CD_TRIG_BIT    = 8;
    localparam int CD_BUSY_BIT    = 31;
    localparam int CD_RESET_RATIO = 8;
    localparam int CD_MIN_RATIO   = 2;

    typedef logic [CD_RATIO_W-1:0] ratio_t;

    // Clamp a programmed ratio to the smallest usable value.
    function automatic ratio_t eff_ratio(input ratio_t r);
        return (r < ratio_t'(CD_MIN_RATIO)) ? ratio_t'(CD_MIN_RATIO) : r;
    endfunction
endpackage

// File: rtl/cdiv_regs.sv
`timescale 1ns/1ps
// Module: cdiv_regs
// Holds the control word and the ratio word and decodes the reload request.
// Assumes single-cycle writes; reads are combinational; busy is merged into
// the control readback and is never stored.
module cdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int EN_OFFSET = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_addr,
    input  logic [CD_DATA_W-1:0] bus_wdata,
    output logic [CD_DATA_W-1:0] bus_rdata,
    input  logic                 busy,
    output logic                 trig,
    output ratio_t               staged_ratio,
    output logic                 en_req
);
    localparam int EN_BIT = CD_FORCE_BIT + EN_OFFSET;
    localparam logic [CD_DATA_W-1:0] BUSY_MASK = CD_DATA_W'(1) << CD_BUSY_BIT;
    localparam logic [CD_DATA_W-1:0] RATIO_RST =
        CD_DATA_W'(CD_RESET_RATIO) << CD_RATIO_LSB;

    logic [CD_DATA_W-1:0] ctl_q;
    logic [CD_DATA_W-1:0] ratio_q;

    // Store software writes; the busy position is kept at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            ratio_q <= RATIO_RST;
        end else if (bus_wr) begin
            if (!bus_addr) ctl_q   <= bus_wdata & ~BUSY_MASK;
            else           ratio_q <= bus_wdata;
        end
    end

    // Readback mux with the live busy flag merged into the control word.
    always_comb begin
        if (!bus_addr) bus_rdata = ctl_q | (busy ? BUSY_MASK : '0);
        else           bus_rdata = ratio_q;
    end

    // A reload request needs both the trigger and the force flag in one write.
    always_comb begin
        trig = bus_wr && !bus_addr && bus_wdata[CD_TRIG_BIT] && bus_wdata[CD_FORCE_BIT];
    end

    assign staged_ratio = ratio_q[CD_RATIO_LSB +: CD_RATIO_W];
    assign en_req       = ctl_q[EN_BIT];
endmodule

// File: rtl/cdiv_reload.sv
`timescale 1ns/1ps
// Module: cdiv_reload
// Captures the staged ratio on a reload request and holds it pending until
// the divider reports that it has consumed it at a period boundary.
// Assumes a request arriving together with an apply keeps the newer value pending.
module cdiv_reload
    import clkdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   trig,
    input  ratio_t staged_ratio,
    input  logic   applied,
    output logic   pend,
    output ratio_t pend_ratio
);
    // Pending flag and captured ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend       <= 1'b0;
            pend_ratio <= ratio_t'(CD_RESET_RATIO);
        end else if (trig) begin
            pend       <= 1'b1;
            pend_ratio <= staged_ratio;
        end else if (applied) begin
            pend       <= 1'b0;
        end
    end
endmodule

// File: rtl/cdiv_counter.sv
`timescale 1ns/1ps
// Module: cdiv_counter
// Period counter with registered, gated output. The ratio and the enable are
// updated only where a new period starts, so no pulse is ever truncated.
// Assumes the active ratio is always at least 2.
module cdiv_counter
    import clkdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en_req,
    input  logic   pend,
    input  ratio_t pend_ratio,
    output logic   applied,
    output logic   clk_out,
    output ratio_t cnt,
    output ratio_t act_ratio
);
    logic   en_q;
    logic   last;
    ratio_t n_cnt;
    ratio_t n_act;
    logic   n_en;

    // Next-state decode for the period position, ratio and gate.
    always_comb begin
        last    = (cnt == act_ratio - ratio_t'(1));
        applied = last && pend;
        n_cnt   = last ? '0 : cnt + ratio_t'(1);
        n_act   = applied ? eff_ratio(pend_ratio) : act_ratio;
        n_en    = last ? en_req : en_q;
    end

    // State and registered output update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            act_ratio <= ratio_t'(CD_RESET_RATIO);
            en_q      <= 1'b0;
            clk_out   <= 1'b0;
        end else begin
            cnt       <= n_cnt;
            act_ratio <= n_act;
            en_q      <= n_en;
            clk_out   <= n_en && (n_cnt < (n_act >> 1));
        end
    end
endmodule

// File: rtl/reload_clk_divider.sv
`timescale 1ns/1ps
// Module: reload_clk_divider (top)
// Register file, reload handshake and divider for one derived clock.
// Assumes clk is the parent clock and that all bus traffic is synchronous to it.
module reload_clk_divider
    import clkdiv_pkg::*;
#(
    parameter int EN_OFFSET = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_addr,
    input  logic [CD_DATA_W-1:0] bus_wdata,
    output logic [CD_DATA_W-1:0] bus_rdata,
    output logic                 clk_out
);
    logic   busy;
    logic   trig;
    logic   en_req;
    logic   applied;
    ratio_t staged_ratio;
    ratio_t pend_ratio;
    ratio_t cnt;
    ratio_t act_ratio;

    cdiv_regs #(.EN_OFFSET(EN_OFFSET)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .trig(trig), .staged_ratio(staged_ratio), .en_req(en_req)
    );

    cdiv_reload u_reload (
        .clk(clk), .rst_n(rst_n), .trig(trig), .staged_ratio(staged_ratio),
        .applied(applied), .pend(busy), .pend_ratio(pend_ratio)
    );

    cdiv_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .pend(busy),
        .pend_ratio(pend_ratio), .applied(applied), .clk_out(clk_out),
        .cnt(cnt), .act_ratio(act_ratio)
    );
endmodule

// File: rtl/cdiv_checker.sv
`timescale 1ns/1ps
// Module: cdiv_checker
// Temporal properties of the divider, attached to the top through bind.
module cdiv_checker
    import clkdiv_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   ctl_wr,
    input logic   wr_trig,
    input logic   wr_force,
    input logic   busy,
    input logic   clk_out,
    input ratio_t cnt,
    input ratio_t act_ratio,
    input ratio_t pend_ratio
);
    // R1: reset leaves the output low and the ratio at its default.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!clk_out && act_ratio == ratio_t'(CD_RESET_RATIO)));

    // R2: every output rising edge starts a new period.
    a_r2_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out) |-> cnt == '0);

    // R4: the active ratio only changes where a period begins.
    a_r4_switch_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_ratio) |-> cnt == '0);

    // R6: busy clears exactly when the captured ratio becomes active.
    a_r6_busy_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> act_ratio == eff_ratio(pend_ratio));

    // R5: a trigger without the force flag never raises busy.
    a_r5_no_force_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_trig && !wr_force && !busy) |=> !busy);
endmodule

bind reload_clk_divider cdiv_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(bus_wr && !bus_addr),
    .wr_trig(bus_wdata[clkdiv_pkg::CD_TRIG_BIT]),
    .wr_force(bus_wdata[clkdiv_pkg::CD_FORCE_BIT]),
    .busy(busy), .clk_out(clk_out), .cnt(cnt),
    .act_ratio(act_ratio), .pend_ratio(pend_ratio)
);

// File: tb/reload_clk_divider_tb.sv
`timescale 1ns/1ps
// Bench: seeded random ratios plus directed corner cases, checked against
// period and high-time values computed from the requirements.
module reload_clk_divider_tb;
    localparam logic [31:0] FORCE = 32'h0000_0002;
    localparam logic [31:0] TRIG  = 32'h0000_0100;
    localparam logic [31:0] EN    = 32'h0200_0000;
    localparam logic [31:0] BUSY  = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        clk_out;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] ctl_sh = '0;
    int cur_ratio = 8;

    reload_clk_divider u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_out(clk_out)
    );

    always #2 clk = ~clk;

    function automatic int exp_period(input int r);
        return (r < 2) ? 2 : r;
    endfunction

    function automatic int exp_high(input int r);
        return exp_period(r) / 2;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Measure one full output period starting at a rising edge.
    task automatic measure(output int per, output int hi);
        logic prev;
        int guard;
        per = -1; hi = -1;
        guard = 0;
        @(negedge clk); prev = clk_out;
        forever begin
            @(negedge clk);
            if (!prev && clk_out) break;
            prev = clk_out;
            guard++;
            if (guard > 400) return;
        end
        per = 0; hi = 0;
        forever begin
            per++;
            if (clk_out) hi++;
            prev = clk_out;
            @(negedge clk);
            if (!prev && clk_out) break;
            if (per > 400) return;
        end
    endtask

    task automatic check_wave(input string req, input int r);
        int p, h;
        measure(p, h);
        check(req, p, exp_period(r));
        check(req, h, exp_high(r));
    endtask

    task automatic do_reload(input int r, input string req);
        logic [31:0] d;
        int guard;
        wr(1'b1, 32'(r) << 8);
        ctl_sh = ctl_sh | FORCE; wr(1'b0, ctl_sh);
        ctl_sh = ctl_sh | TRIG;  wr(1'b0, ctl_sh);
        rd(1'b0, d);
        check({req, " busy after trigger"}, d[31], 1);
        guard = 0;
        while (d[31] && guard < 500) begin
            @(negedge clk); rd(1'b0, d); guard++;
        end
        check({req, " busy clears"}, d[31], 0);
        ctl_sh = ctl_sh & ~(32'h0000_00FF | TRIG);
        wr(1'b0, ctl_sh);
        cur_ratio = r;
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int hi_seen;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        hi_seen = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (clk_out) hi_seen++; end
        check("R1 clk_out low", hi_seen, 0);
        rd(1'b0, d); check("R1 control", d, 32'h0);
        rd(1'b1, d); check("R1 ratio", d, 32'h0000_0800);

        // R8/R2: enable, default ratio 8
        ctl_sh = EN; wr(1'b0, ctl_sh);
        check_wave("R2 R8 ratio 8", 8);

        // R3: staging without trigger leaves the period alone
        wr(1'b1, 32'(5) << 8);
        check_wave("R3 staged only", 8);

        // R4/R6: supported ratios
        do_reload(4, "R4 R6 r4"); check_wave("R4 R2 ratio 4", 4);
        do_reload(5, "R4 R6 r5"); check_wave("R4 R2 ratio 5", 5);
        do_reload(6, "R4 R6 r6"); check_wave("R4 R2 ratio 6", 6);

        // R5: trigger without force
        wr(1'b1, 32'(8) << 8);
        ctl_sh = ctl_sh | TRIG; wr(1'b0, ctl_sh);
        rd(1'b0, d); check("R5 busy stays low", d[31], 0);
        check_wave("R5 period unchanged", 6);
        ctl_sh = ctl_sh & ~TRIG; wr(1'b0, ctl_sh);

        // R7/R6: unrelated bits preserved, busy not writable
        ctl_sh = EN | 32'h0055_00A0;
        wr(1'b0, ctl_sh | BUSY);
        rd(1'b0, d); check("R7 R6 control readback", d, ctl_sh);
        wr(1'b1, 32'hA5C3_1B0F);
        rd(1'b1, d); check("R7 ratio readback", d, 32'hA5C3_1B0F);
        do_reload(8, "R7 r8"); check_wave("R7 enable kept ratio 8", 8);

        // R9: ratios 0 and 1 act as 2
        do_reload(0, "R9 r0"); check_wave("R9 ratio 0", 0);
        do_reload(1, "R9 r1"); check_wave("R9 ratio 1", 1);

        // R2: seeded random ratios
        for (int k = 0; k < 10; k++) begin
            int r;
            r = int'($urandom_range(63, 2));
            do_reload(r, "R2 rand");
            check_wave("R2 random ratio", r);
        end

        // R8: disable holds output low; reload still completes
        ctl_sh = ctl_sh & ~EN; wr(1'b0, ctl_sh);
        repeat (70) @(negedge clk);
        hi_seen = 0;
        for (int i = 0; i < 140; i++) begin @(negedge clk); if (clk_out) hi_seen++; end
        check("R8 disabled low", hi_seen, 0);
        do_reload(4, "R8 r4 disabled");
        ctl_sh = ctl_sh | EN; wr(1'b0, ctl_sh);
        check_wave("R8 R4 re-enabled ratio 4", 4);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule